// File: doc/BRIEF.md
# Reloading Countdown Timers with Timestamp Counter

This block holds three countdown timers and one free-running timestamp counter, all reached through a simple 32-bit register bus with word addressing. The first two timers are 16 bits wide and the third is 32 bits wide. Each timer steps down by one on a tick strobe, and its control word picks one of two strobes. When it steps past zero it raises a sticky interrupt. It then either reloads from its load register or wraps to its all-ones value. The interrupt stays set until software writes any value to that timer's clear register.

The timestamp counter is 40 bits wide and counts up on a third, faster strobe. It never raises an interrupt. Software reads it as a low 32-bit word and a high word. The high word also holds the enable bit. All tick inputs are single-cycle enable strobes in the system clock domain. Register writes take effect at the clock edge, and read data is combinational from the address.

Word address map: `bus_addr[3:2]` selects timer 1, 2, 3 or the timestamp counter (0..3). `bus_addr[1:0]` selects the register. For a timer, 0 is load, 1 is value (read-only), 2 is control and 3 is clear. For the timestamp counter, 0 is the low count (read-only) and 1 is the high word. Timer control bits are: bit 7 enable, bit 6 tick select (1 = `fast_tick`, 0 = `slow_tick`), and bit 3 periodic reload. Other control bits read as zero.

Top module: `tick_timer_set`

## Requirements
- R1: After reset, every load, value and control register reads zero, the timestamp words read zero and `tmr_irq` is 0.
- R2: Writing control with bit 7 set while the timer is disabled copies the load register into the counter. While a timer is disabled its counter does not change. Control reads back bits 7, 6 and 3 as written.
- R3: An enabled timer decrements by exactly one per pulse of the strobe chosen by control bit 6 (1 = `fast_tick`, 0 = `slow_tick`). The other strobe has no effect.
- R4: In periodic mode (bit 3 = 1), a load value of N-1 gives one underflow every N ticks. The counter reloads to the load value on the tick that steps from zero.
- R5: In free-running mode (bit 3 = 0), the tick that steps from zero sets the counter to all ones: 0xFFFF for timers 1 and 2, and 0xFFFFFFFF for timer 3.
- R6: Each underflow sets that timer's bit of `tmr_irq`. The bit stays set until a write of any data value to that timer's clear register, and it falls on the edge of that write.
- R7: When an underflow and a clear write fall on the same edge, the interrupt bit ends set.
- R8: Writing the load register of a running timer leaves the counter unchanged. The new value is used from the next reload.
- R9: Timers 1 and 2 keep only the low 16 bits of a load write. Timer 3 keeps all 32 bits.
- R10: The timestamp counter increments by one per `stamp_tick` pulse while the enable bit (bit 8 of the high word) is set. It holds its value while disabled. Enabling it from the disabled state restarts it at zero. It never changes `tmr_irq`.
- R11: The high word reads the enable bit in bit 8 and count bits 39:32 in bits 7:0. The low word reads count bits 31:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_tick | input | 1 | Fast countdown strobe, one cycle wide |
| slow_tick | input | 1 | Alternative countdown strobe, one cycle wide |
| stamp_tick | input | 1 | Timestamp counter strobe, one cycle wide |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | 4 | Word address: block in [3:2], register in [1:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tmr_irq | output | 3 | Sticky underflow interrupts, bit i for timer i+1 |

## Verification
The underflow that sets an interrupt and the software write that clears it can fall on the same clock edge. The bench sets up this case by bringing timer 1 to zero with the interrupt clear. It then drives `fast_tick` in the same cycle as a write to the clear register. The check passes only if `tmr_irq[0]` is still set and the counter has reloaded. A later lone clear must then drop the bit.

// File: rtl/tick_timer_pkg.sv
// Package: shared control-bit positions and register indices for the timer set.
// Assumes word addressing with a 2-bit block field and a 2-bit register field.
package tick_timer_pkg;
    localparam int CTL_EN_BIT    = 7;
    localparam int CTL_FAST_BIT  = 6;
    localparam int CTL_PER_BIT   = 3;
    localparam int STAMP_EN_BIT  = 8;
    localparam int REG_IDX_W     = 2;
    localparam int BLK_IDX_W     = 2;

    typedef enum logic [REG_IDX_W-1:0] {
        TR_LOAD  = 2'd0,
        TR_VALUE = 2'd1,
        TR_CTRL  = 2'd2,
        TR_CLEAR = 2'd3
    } timer_reg_e;

    typedef enum logic [REG_IDX_W-1:0] {
        SR_LOW  = 2'd0,
        SR_HIGH = 2'd1
    } stamp_reg_e;
endpackage

// File: rtl/countdown_timer.sv
// Module: one reloading countdown timer of parameter width W.
// Assumes the ticks are one-cycle strobes in the clk domain and that at most
// one register write arrives per cycle. The enable edge takes priority over a
// tick in the same cycle. An underflow takes priority over a clear.
module countdown_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fast_tick,
    input  logic         slow_tick,
    input  logic         load_we,
    input  logic         ctrl_we,
    input  logic         clr_we,
    input  logic [W-1:0] load_d,
    input  logic         en_d,
    input  logic         fast_d,
    input  logic         per_d,
    output logic [W-1:0] load_q,
    output logic [W-1:0] cnt_q,
    output logic         en_q,
    output logic         fast_q,
    output logic         per_q,
    output logic         irq
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic tick_sel;
    logic step;
    logic at_zero;
    logic start;

    // Pick the strobe named by the control word.
    always_comb begin
        tick_sel = fast_q ? fast_tick : slow_tick;
        step     = en_q && tick_sel;
        at_zero  = (cnt_q == '0);
        start    = ctrl_we && en_d && !en_q;
    end

    // Load and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
            en_q   <= 1'b0;
            fast_q <= 1'b0;
            per_q  <= 1'b0;
        end else begin
            if (load_we) load_q <= load_d;
            if (ctrl_we) begin
                en_q   <= en_d;
                fast_q <= fast_d;
                per_q  <= per_d;
            end
        end
    end

    // Counter: copy the load value on enable, otherwise step, reload or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= load_q;
        end else if (step) begin
            if (at_zero) cnt_q <= per_q ? load_q : ALL_ONES;
            else         cnt_q <= cnt_q - 1'b1;
        end
    end

    // Sticky interrupt: set by underflow, dropped by a clear write.
    always_ff @(posedge clk) begin
        if (!rst_n)                          irq <= 1'b0;
        else if (step && at_zero && !start)  irq <= 1'b1;
        else if (clr_we)                     irq <= 1'b0;
    end

    assert_load_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && en_d && !en_q) |=> (cnt_q == $past(load_q)));
    assert_hold_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !ctrl_we) |=> $stable(cnt_q));
    assert_wrap_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && tick_sel && !per_q && cnt_q == '0 && !ctrl_we) |=> (cnt_q == ALL_ONES));
    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_we) |=> irq);
    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(cnt_q) == '0));
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && tick_sel && cnt_q == '0 && !ctrl_we) |=> irq);
endmodule

// File: rtl/stamp_counter.sv
// Module: free-running up-counter for timestamps, width CW, with an enable bit.
// Assumes one-cycle strobes. A write to the enable register in a cycle wins
// over a tick in the same cycle. Enabling from disabled restarts at zero.
module stamp_counter #(
    parameter int CW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stamp_tick,
    input  logic          en_we,
    input  logic          en_d,
    output logic          en_q,
    output logic [CW-1:0] cnt_q
);
    // Enable register and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            cnt_q <= '0;
        end else if (en_we) begin
            en_q <= en_d;
            if (en_d && !en_q) cnt_q <= '0;
        end else if (en_q && stamp_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_hold_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !en_we) |=> $stable(cnt_q));
    assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we && en_d && !en_q) |=> (cnt_q == '0));
    assert_step_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && stamp_tick && !en_we) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/tick_timer_set.sv
// Module: top of the timer set. Three countdown timers (two narrow, one wide)
// and a timestamp counter, with register decode and a read mux.
// Assumes word addressing: block in bus_addr[3:2], register in bus_addr[1:0].
module tick_timer_set
    import tick_timer_pkg::*;
#(
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32,
    parameter int STAMP_W  = 40,
    parameter int N_TMR    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast_tick,
    input  logic             slow_tick,
    input  logic             stamp_tick,
    input  logic             bus_we,
    input  logic [3:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic [N_TMR-1:0] tmr_irq
);
    localparam int HI_W = STAMP_W - 32;

    logic [BLK_IDX_W-1:0] blk;
    logic [REG_IDX_W-1:0] rsel;
    logic [31:0]          t_load [N_TMR];
    logic [31:0]          t_cnt  [N_TMR];
    logic [31:0]          t_ctrl [N_TMR];
    logic                 s_en;
    logic [STAMP_W-1:0]   s_cnt;
    logic                 s_we;

    // Split the word address into block and register fields.
    always_comb begin
        blk  = bus_addr[3:2];
        rsel = bus_addr[1:0];
        s_we = bus_we && (blk == BLK_IDX_W'(N_TMR)) && (rsel == SR_HIGH);
    end

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        localparam int TW = (i == N_TMR - 1) ? WIDE_W : NARROW_W;
        logic [TW-1:0] load_q;
        logic [TW-1:0] cnt_q;
        logic          en_q, fast_q, per_q;
        logic          hit;

        // Decode this timer's block.
        always_comb hit = bus_we && (blk == BLK_IDX_W'(i));

        countdown_timer #(.W(TW)) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .fast_tick (fast_tick),
            .slow_tick (slow_tick),
            .load_we   (hit && rsel == TR_LOAD),
            .ctrl_we   (hit && rsel == TR_CTRL),
            .clr_we    (hit && rsel == TR_CLEAR),
            .load_d    (bus_wdata[TW-1:0]),
            .en_d      (bus_wdata[CTL_EN_BIT]),
            .fast_d    (bus_wdata[CTL_FAST_BIT]),
            .per_d     (bus_wdata[CTL_PER_BIT]),
            .load_q    (load_q),
            .cnt_q     (cnt_q),
            .en_q      (en_q),
            .fast_q    (fast_q),
            .per_q     (per_q),
            .irq       (tmr_irq[i])
        );

        // Zero-extend this timer's registers for the read mux.
        always_comb begin
            t_load[i]               = 32'(load_q);
            t_cnt[i]                = 32'(cnt_q);
            t_ctrl[i]               = '0;
            t_ctrl[i][CTL_EN_BIT]   = en_q;
            t_ctrl[i][CTL_FAST_BIT] = fast_q;
            t_ctrl[i][CTL_PER_BIT]  = per_q;
        end
    end

    stamp_counter #(.CW(STAMP_W)) u_stamp (
        .clk        (clk),
        .rst_n      (rst_n),
        .stamp_tick (stamp_tick),
        .en_we      (s_we),
        .en_d       (bus_wdata[STAMP_EN_BIT]),
        .en_q       (s_en),
        .cnt_q      (s_cnt)
    );

    // Read mux over all blocks.
    always_comb begin
        bus_rdata = '0;
        if (blk < BLK_IDX_W'(N_TMR)) begin
            case (rsel)
                TR_LOAD:  bus_rdata = t_load[blk];
                TR_VALUE: bus_rdata = t_cnt[blk];
                TR_CTRL:  bus_rdata = t_ctrl[blk];
                default:  bus_rdata = '0;
            endcase
        end else begin
            case (rsel)
                SR_LOW:  bus_rdata = s_cnt[31:0];
                SR_HIGH: begin
                    bus_rdata[HI_W-1:0]   = s_cnt[STAMP_W-1:32];
                    bus_rdata[STAMP_EN_BIT] = s_en;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    assert_stamp_no_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we == 1'b0 && fast_tick == 1'b0 && slow_tick == 1'b0) |=> $stable(tmr_irq));
    assert_irq_idle_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (tmr_irq == '0));
endmodule

// File: tb/tick_timer_set_tb.sv
// Bench: directed scenarios, one task each, each task checking its own results.
module tick_timer_set_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_tick = 1'b0, slow_tick = 1'b0, stamp_tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  tmr_irq;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tick_timer_set u_dut (
        .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
        .stamp_tick(stamp_tick), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_irq(tmr_irq)
    );

    function automatic logic [3:0] ad(input int blk, input int r);
        return 4'(blk * 4 + r);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk); bus_addr = a; #1;
        chk(tag, bus_rdata, exp);
    endtask

    // kind: 0 fast, 1 slow, 2 stamp
    task automatic ticks(input int kind, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            fast_tick = (kind == 0); slow_tick = (kind == 1); stamp_tick = (kind == 2);
            @(negedge clk);
            fast_tick = 1'b0; slow_tick = 1'b0; stamp_tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        rd("R1 load1", ad(0,0), 0);
        rd("R1 value1", ad(0,1), 0);
        rd("R1 ctrl1", ad(0,2), 0);
        rd("R1 value3", ad(2,1), 0);
        rd("R1 stamp low", ad(3,0), 0);
        rd("R1 stamp high", ad(3,1), 0);
        chk("R1 irq", 32'(tmr_irq), 0);
    endtask

    task automatic t_periodic;
        wr(ad(0,2), 32'h48);
        wr(ad(0,0), 32'd3);
        ticks(0, 2);
        rd("R2 disabled hold", ad(0,1), 0);
        wr(ad(0,2), 32'hC8);
        rd("R2 ctrl readback", ad(0,2), 32'hC8);
        rd("R2 copy on enable", ad(0,1), 3);
        ticks(0, 3);
        rd("R4 at zero", ad(0,1), 0);
        chk("R4 no irq before N", 32'(tmr_irq[0]), 0);
        ticks(0, 1);
        chk("R4 irq after N ticks", 32'(tmr_irq[0]), 1);
        rd("R4 reload", ad(0,1), 3);
        repeat (5) @(negedge clk);
        chk("R6 sticky", 32'(tmr_irq[0]), 1);
        wr(ad(0,3), 32'hDEAD_0000);
        chk("R6 clear any data", 32'(tmr_irq[0]), 0);
    endtask

    task automatic t_load_running;
        wr(ad(0,0), 32'd7);
        rd("R8 value unchanged", ad(0,1), 3);
        ticks(0, 4);
        rd("R8 new reload", ad(0,1), 7);
        chk("R8 irq", 32'(tmr_irq[0]), 1);
        wr(ad(0,3), 0);
    endtask

    task automatic t_select;
        wr(ad(1,0), 32'd5);
        wr(ad(1,2), 32'h88);
        rd("R2 timer2 copy", ad(1,1), 5);
        ticks(0, 3);
        rd("R3 other strobe ignored", ad(1,1), 5);
        ticks(1, 2);
        rd("R3 slow strobe counts", ad(1,1), 3);
    endtask

    task automatic t_wrap;
        wr(ad(1,2), 32'h00);
        wr(ad(1,0), 32'd0);
        wr(ad(1,2), 32'hC0);
        ticks(0, 1);
        rd("R5 narrow wrap", ad(1,1), 32'h0000_FFFF);
        chk("R5 narrow irq", 32'(tmr_irq[1]), 1);
        wr(ad(2,2), 32'h40);
        wr(ad(2,0), 32'd1);
        wr(ad(2,2), 32'hC0);
        ticks(0, 2);
        rd("R5 wide wrap", ad(2,1), 32'hFFFF_FFFF);
        chk("R5 wide irq", 32'(tmr_irq[2]), 1);
    endtask

    task automatic t_collide;
        wr(ad(0,2), 32'h48);
        wr(ad(0,0), 32'd1);
        wr(ad(0,2), 32'hC8);
        wr(ad(0,3), 0);
        ticks(0, 1);
        rd("R7 at zero", ad(0,1), 0);
        chk("R7 irq clear before", 32'(tmr_irq[0]), 0);
        @(negedge clk);
        fast_tick = 1'b1; bus_we = 1'b1; bus_addr = ad(0,3); bus_wdata = 32'h1;
        @(negedge clk);
        fast_tick = 1'b0; bus_we = 1'b0;
        chk("R7 set wins over clear", 32'(tmr_irq[0]), 1);
        rd("R7 reloaded", ad(0,1), 1);
        wr(ad(0,3), 0);
        chk("R7 lone clear", 32'(tmr_irq[0]), 0);
    endtask

    task automatic t_widths;
        wr(ad(0,0), 32'hFFFF_1234);
        rd("R9 narrow load", ad(0,0), 32'h0000_1234);
        wr(ad(2,0), 32'h89AB_CDEF);
        rd("R9 wide load", ad(2,0), 32'h89AB_CDEF);
    endtask

    task automatic t_stamp;
        logic [2:0] irq0;
        irq0 = tmr_irq;
        ticks(2, 3);
        rd("R10 off holds", ad(3,0), 0);
        wr(ad(3,1), 32'h100);
        ticks(2, 5);
        ticks(0, 0);
        rd("R10 counts", ad(3,0), 5);
        rd("R11 high word", ad(3,1), 32'h100);
        chk("R10 no irq effect", 32'(tmr_irq), 32'(irq0));
        wr(ad(3,1), 32'h0);
        ticks(2, 4);
        rd("R10 disabled hold", ad(3,0), 5);
        rd("R11 high off", ad(3,1), 0);
        wr(ad(3,1), 32'h100);
        rd("R10 restart zero", ad(3,0), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_periodic();
        t_load_running();
        t_select();
        t_wrap();
        t_collide();
        t_widths();
        t_stamp();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule